// File: doc/BRIEF.md
# Streaming Chunk Hamming Parity Generator

This block sits beside the byte path between a host and a raw flash device and computes a single-error-correcting Hamming parity over the bytes as they stream past. The stream is split into fixed chunks of `CHUNK_BYTES` bytes, 256 by default. Each chunk gets its own code. The block counts accepted bytes and, when a chunk's last byte is taken, publishes the chunk's parity and pulses a done flag. It then starts the next chunk from zero without any software action.

Two views of the result are offered. The raw view carries six column-parity bits in its low bits and two line-parity bits for every bit of the byte index above them: 22 bits for a 256-byte chunk. The spare-area view is the 3-byte word that a host writes next to the data. A clear pulse throws away any chunk in progress, and bytes only count while the enable input is high.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset, `par_raw` is 0, `chunk_done` is 0, and every byte of `code_bytes` is 8'hFF.
- R2: Column parity sits in `par_raw[5:0]`. For k in 0..2, bit 2k is the XOR of every data bit whose bit position has bit k equal to 0, and bit 2k+1 is the XOR of those whose position has bit k equal to 1. All accepted bytes of the chunk take part.
- R3: Line parity sits from bit 6 upward. For each byte-index bit k (0..IDX_W-1), bit 6+2k is the XOR of the byte parities (XOR of all 8 bits) of the bytes whose index in the chunk has bit k equal to 0. Bit 7+2k covers the bytes whose index has bit k equal to 1. The first accepted byte of a chunk has index 0.
- R4: A byte is accepted on a rising edge where `ecc_en` and `byte_vld` are high and `ecc_clr` is low. On the edge that accepts the CHUNK_BYTES-th byte, `par_raw` takes that chunk's parity and `chunk_done` goes high for exactly that one cycle.
- R5: After a chunk completes, the next accepted byte has index 0 and the next chunk's parity does not depend on earlier chunks.
- R6: Let S be the 24-bit value ~{par_raw, 2'b00}. `code_bytes[0]` is S[23:16], `code_bytes[1]` is S[15:8] and `code_bytes[2]` is S[7:0], in that order of emission.
- R7: A cycle with `ecc_clr` high sets `par_raw` to 0, drops `chunk_done`, discards the partial chunk and ignores any byte offered in the same cycle. The next accepted byte has index 0.
- R8: A byte offered while `ecc_en` is low is neither counted nor folded into parity.
- R9: Between completions and clears, `par_raw` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Parity accumulation enable |
| ecc_clr | input | 1 | Discard the chunk in progress and zero the result |
| byte_vld | input | 1 | A byte is present on `byte_dat` |
| byte_dat | input | 8 | Streamed data byte |
| par_raw | output | 6+2*IDX_W | Parity of the last completed chunk |
| code_bytes | output | CODE_BYTES x 8 | Stored-form bytes, index 0 emitted first |
| chunk_done | output | 1 | One-cycle pulse when a chunk completes |

## Verification
The bench builds the block with its default chunk of 256 bytes, so the index counter wraps at full width and all sixteen line-parity bits are exercised. Single-bit patterns at the first and last index give hand-known codes that pin down both parity families. Random streams with enable gaps, clears in mid-chunk and a clear that coincides with a valid byte test the counting and restart rules at the real chunk size.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;

    localparam int COL_W  = 6;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_TAKE  = 2'd2
    } beat_op_e;

    typedef struct packed {
        beat_op_e          op;
        logic [BYTE_W-1:0] data;
    } beat_t;

    function automatic logic [COL_W-1:0] col_contrib(input logic [BYTE_W-1:0] b);
        logic [COL_W-1:0] c;
        c = '0;
        for (int j = 0; j < BYTE_W; j++) begin
            for (int k = 0; k < 3; k++) begin
                if (j[k]) c[2*k+1] = c[2*k+1] ^ b[j];
                else      c[2*k]   = c[2*k]   ^ b[j];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/ecc_chunk_counter.sv
module ecc_chunk_counter #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (take) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IDX_MAX);
endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
    import ecc_stream_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int RAW_W = COL_W + 2*IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             beat,
    input  logic [IDX_W-1:0]  idx,
    input  logic              last,
    output logic [RAW_W-1:0]  result,
    output logic              done
);
    logic [RAW_W-1:0]   acc;
    logic [2*IDX_W-1:0] line_c;
    logic [COL_W-1:0]   col_c;
    logic               byte_par;
    logic [RAW_W-1:0]   acc_nxt;

    assign byte_par = ^beat.data;
    assign col_c    = col_contrib(beat.data);

    for (genvar k = 0; k < IDX_W; k++) begin : g_line
        assign line_c[2*k]   = byte_par & ~idx[k];
        assign line_c[2*k+1] = byte_par &  idx[k];
    end

    assign acc_nxt = acc ^ {line_c, col_c};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (beat.op)
                OP_CLEAR: begin
                    acc    <= '0;
                    result <= '0;
                end
                OP_TAKE: begin
                    if (last) begin
                        result <= acc_nxt;
                        acc    <= '0;
                        done   <= 1'b1;
                    end else begin
                        acc <= acc_nxt;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ecc_code_packer.sv
module ecc_code_packer #(
    parameter int RAW_W = 22,
    localparam int NB   = (RAW_W + 2 + 7) / 8
) (
    input  logic [RAW_W-1:0]      raw,
    output logic [NB-1:0][7:0]    code
);
    logic [NB*8-1:0] word;

    always_comb begin
        word = '0;
        word[RAW_W+1:2] = raw;
        word = ~word;
    end

    for (genvar n = 0; n < NB; n++) begin : g_byte
        assign code[n] = word[(NB-1-n)*8 +: 8];
    end
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
    import ecc_stream_pkg::*;
#(
    parameter int CHUNK_BYTES = 256,
    localparam int IDX_W      = $clog2(CHUNK_BYTES),
    localparam int RAW_W      = COL_W + 2*IDX_W,
    localparam int CODE_BYTES = (RAW_W + 2 + 7) / 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ecc_en,
    input  logic                        ecc_clr,
    input  logic                        byte_vld,
    input  logic [7:0]                  byte_dat,
    output logic [RAW_W-1:0]            par_raw,
    output logic [CODE_BYTES-1:0][7:0]  code_bytes,
    output logic                        chunk_done
);
    beat_t            beat;
    logic [IDX_W-1:0] idx;
    logic             last;

    always_comb begin
        beat.data = byte_dat;
        if (ecc_clr)                 beat.op = OP_CLEAR;
        else if (ecc_en && byte_vld) beat.op = OP_TAKE;
        else                         beat.op = OP_IDLE;
    end

    ecc_chunk_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (beat.op == OP_CLEAR),
        .take (beat.op == OP_TAKE),
        .idx  (idx),
        .last (last)
    );

    ecc_parity_accum #(.IDX_W(IDX_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .beat   (beat),
        .idx    (idx),
        .last   (last),
        .result (par_raw),
        .done   (chunk_done)
    );

    ecc_code_packer #(.RAW_W(RAW_W)) u_pack (
        .raw  (par_raw),
        .code (code_bytes)
    );
endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk #(
    parameter int RAW_W = 22
) (
    input logic             clk,
    input logic             rst,
    input logic             ecc_en,
    input logic             ecc_clr,
    input logic             byte_vld,
    input logic [RAW_W-1:0] par_raw,
    input logic             chunk_done
);
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        chunk_done |=> !chunk_done);

    a_r4_done_needs_take: assert property (@(posedge clk) disable iff (rst)
        chunk_done |-> $past(ecc_en && byte_vld && !ecc_clr));

    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        $past(ecc_clr) |-> (par_raw == '0 && !chunk_done));

    a_r8_no_take_no_done: assert property (@(posedge clk) disable iff (rst)
        !(ecc_en && byte_vld) |=> !chunk_done);

    a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!chunk_done && !$past(ecc_clr)) |-> $stable(par_raw));
endmodule

bind ecc_stream_gen ecc_stream_gen_chk #(.RAW_W(RAW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ecc_en     (ecc_en),
    .ecc_clr    (ecc_clr),
    .byte_vld   (byte_vld),
    .par_raw    (par_raw),
    .chunk_done (chunk_done)
);

// File: tb/ecc_stream_gen_test.sv
module ecc_stream_gen_test;
    localparam int CHUNK = 256;
    localparam int RAW_W = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ecc_en = 1'b0, ecc_clr = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_dat = '0;
    logic [RAW_W-1:0] par_raw;
    logic [2:0][7:0] code_bytes;
    logic chunk_done;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ecc_stream_gen #(.CHUNK_BYTES(CHUNK)) uut (
        .clk(clk), .rst(rst), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .par_raw(par_raw),
        .code_bytes(code_bytes), .chunk_done(chunk_done)
    );

    logic [7:0]       mbuf [CHUNK];
    int               mcnt = 0;
    logic [RAW_W-1:0] exp_raw = '0;
    logic             exp_done = 1'b0;

    function automatic logic [RAW_W-1:0] model_par();
        logic [5:0]  col = '0;
        logic [15:0] line = '0;
        for (int i = 0; i < CHUNK; i++) begin
            logic lp = ^mbuf[i];
            for (int j = 0; j < 8; j++)
                for (int k = 0; k < 3; k++)
                    if (mbuf[i][j]) col[2*k + ((j >> k) & 1)] ^= 1'b1;
            for (int k = 0; k < 8; k++)
                if (lp) line[2*k + ((i >> k) & 1)] ^= 1'b1;
        end
        return {line, col};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        logic [23:0] s;
        s = ~{exp_raw, 2'b00};
        chk(chunk_done == exp_done, tag, "chunk_done", 32'(chunk_done), 32'(exp_done));
        chk(par_raw == exp_raw, tag, "par_raw", 32'(par_raw), 32'(exp_raw));
        chk({code_bytes[0], code_bytes[1], code_bytes[2]} == s, "R6", "code_bytes",
            32'({code_bytes[0], code_bytes[1], code_bytes[2]}), 32'(s));
    endtask

    task automatic step(input logic en, input logic vld, input logic clr,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        ecc_en = en; byte_vld = vld; ecc_clr = clr; byte_dat = d;
        @(posedge clk);
        #1;
        exp_done = 1'b0;
        if (clr) begin
            mcnt = 0;
            exp_raw = '0;
        end else if (en && vld) begin
            mbuf[mcnt] = d;
            if (mcnt == CHUNK - 1) begin
                exp_raw = model_par();
                exp_done = 1'b1;
                mcnt = 0;
            end else begin
                mcnt++;
            end
        end
        check_outs(tag);
    endtask

    task automatic rand_chunk(input string tag);
        int got = 0;
        while (got < CHUNK) begin
            logic en  = ($urandom % 4) != 0;
            logic vld = ($urandom % 5) != 0;
            step(en, vld, 1'b0, 8'($urandom), tag);
            if (en && vld) got++;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        chk(par_raw == '0, "R1", "par_raw", 32'(par_raw), 0);
        chk(chunk_done == 1'b0, "R1", "chunk_done", 32'(chunk_done), 0);
        chk({code_bytes[0], code_bytes[1], code_bytes[2]} == 24'hFFFFFF, "R1", "code_bytes",
            32'({code_bytes[0], code_bytes[1], code_bytes[2]}), 32'hFFFFFF);

        // R2 R3: single bit 0 of byte index 0
        step(1, 1, 0, 8'h01, "R3");
        for (int i = 1; i < CHUNK; i++) step(1, 1, 0, 8'h00, "R4");
        chk(par_raw == 22'h155555, "R2", "single low bit", 32'(par_raw), 32'h155555);

        // R5: next chunk restarts; bit 7 of the last byte
        for (int i = 0; i < CHUNK - 1; i++) step(1, 1, 0, 8'h00, "R5");
        step(1, 1, 0, 8'h80, "R5");
        chk(par_raw == 22'h2AAAAA, "R3", "single high bit", 32'(par_raw), 32'h2AAAAA);

        // R9: hold while idle
        for (int i = 0; i < 6; i++) step(1, 0, 0, 8'h5A, "R9");

        // R4 R8: random chunks with enable gaps
        for (int c = 0; c < 4; c++) rand_chunk("R8");

        // R7: partial chunk discarded, clear with a valid byte
        for (int i = 0; i < 100; i++) step(1, 1, 0, 8'($urandom), "R7");
        step(1, 1, 1, 8'hFF, "R7");
        for (int i = 0; i < 40; i++) step(1, 1, 0, 8'($urandom), "R7");
        step(1, 1, 1, 8'h3C, "R7");
        rand_chunk("R7");

        // R8: enable low, long stream, nothing completes
        for (int i = 0; i < 300; i++) step(0, 1, 0, 8'($urandom), "R8");
        rand_chunk("R5");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 8'h00, "R9");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog R4 actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule